// File: doc/BRIEF.md
# SIR Receive Frame Unwrapper

This block sits behind an asynchronous infrared byte receiver and turns the raw byte stream of a slow-rate link into bare packets. A frame opens on the start flag 0xC0 and closes on the end flag 0xC1. Any start flags repeated before the first payload byte are absorbed. The control-escape byte 0x7D is removed, and the byte after it is restored by XOR with 0x20. What remains, the link payload together with its trailing 16-bit FCS, leaves on a valid/ready byte port. The last byte of each packet carries an end-of-packet mark and the packet's error flags.

Because the end of a packet is only known when the end flag arrives, the block holds back one payload byte. That byte is released either when the next payload byte arrives or, marked as last, when the frame closes. The block keeps a 12-bit count of the payload bytes in the current frame and compares it against a programmable limit. It also reports a frame that is cut short by a fresh start flag. When filtering is not active, bytes pass straight through.

Top module: `sir_rx_unwrap`

## Requirements
- R1: `flag_word` always reads 16'hC1C0: end flag in bits 15:8, start flag in bits 7:0.
- R2: Bytes accepted while no frame is open are discarded, and a start flag 0xC0 opens a frame. Nothing is forwarded for flags or for bytes outside a frame.
- R3: Further 0xC0 bytes arriving after a frame opens but before any payload byte raise no error and forward nothing.
- R4: Inside a frame, 0xC0, 0xC1 and 0x7D are never forwarded as themselves. The byte following 0x7D is forwarded as that byte XOR 0x20, even when the result is 0xC0, 0xC1 or 0x7D.
- R5: On 0xC1 the held payload byte is emitted with `out_eop`=1 and the block returns to idle. A frame with no payload emits nothing.
- R6: A 0xC0 arriving after payload with no 0xC1 emits the held byte with `out_eop`=1 and `out_sir_bad`=1, then starts a new frame.
- R7: `byte_count` is 0 after reset and at every frame start. It rises by one for each payload byte of the current frame and saturates at 4095.
- R8: When a payload byte arrives while `byte_count` >= `max_len`, the frame's end-of-packet byte carries `out_too_long`=1.
- R9: Filtering is active only when `filt_en`=1 and either `sir_mode`=1 or `test_en`=1. Otherwise every accepted byte is forwarded unchanged with `out_eop`, `out_sir_bad` and `out_too_long` at 0, and `byte_count` is held at 0.
- R10: An output byte appears the cycle after the input that produced it. It stays valid and stable until `out_ready`=1. `in_ready` = !`out_valid` || `out_ready`.
- R11: `out_sir_bad` and `out_too_long` are only ever 1 together with `out_eop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sir_mode | input | 1 | Slow-rate mode selected |
| filt_en | input | 1 | Unwrapping filter enable |
| test_en | input | 1 | Allow filter outside slow-rate mode |
| max_len | input | 12 | Largest accepted payload length in bytes |
| in_valid | input | 1 | Received byte valid |
| in_byte | input | 8 | Received byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_byte | output | 8 | Payload byte |
| out_eop | output | 1 | Last byte of packet |
| out_sir_bad | output | 1 | Frame closed by a start flag (end flag missing) |
| out_too_long | output | 1 | Frame exceeded `max_len` |
| byte_count | output | 12 | Payload bytes in current frame |
| flag_word | output | 16 | Fixed start/end flag codes |

## Verification
The consumer draining a stalled output byte and the block accepting the input that produces the next one can fall into the same cycle. The bench provokes this by holding `out_ready` low until `in_ready` drops and a pending end flag is refused. It then raises `out_ready` with the end flag still offered. The held byte must stay frozen during the stall, and the very next cycle must show the following byte marked as last with no byte lost or duplicated. A second coincidence is a start flag that both closes a frame with an error and opens the next; that case is judged by the emitted error byte and by `byte_count` returning to zero in the same cycle.

// File: rtl/sir_unwrap_pkg.sv
package sir_unwrap_pkg;

    localparam logic [7:0] FLAG_BOF  = 8'hC0;
    localparam logic [7:0] FLAG_EOF  = 8'hC1;
    localparam logic [7:0] CODE_ESC  = 8'h7D;
    localparam logic [7:0] ESC_XOR   = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_ESC
    } fr_state_e;

    typedef enum logic [1:0] {
        K_BOF,
        K_EOF,
        K_ESC,
        K_DATA
    } byte_kind_e;

    typedef struct packed {
        logic sir_bad;
        logic too_long;
    } rx_err_t;

    typedef struct packed {
        logic [7:0] data;
        logic       eop;
        rx_err_t    err;
    } rx_beat_t;

    function automatic byte_kind_e classify(input logic [7:0] b);
        if (b == FLAG_BOF)      return K_BOF;
        else if (b == FLAG_EOF) return K_EOF;
        else if (b == CODE_ESC) return K_ESC;
        else                    return K_DATA;
    endfunction

endpackage

// File: rtl/sir_unwrap_fsm.sv
module sir_unwrap_fsm
    import sir_unwrap_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             take,
    input  logic [7:0]       in_byte,
    input  logic [LEN_W-1:0] max_len,
    output logic             emit,
    output rx_beat_t         beat,
    output logic [LEN_W-1:0] byte_count
);

    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

    fr_state_e        state_q, state_d;
    logic             pend_v_q, pend_v_d;
    logic [7:0]       pend_b_q, pend_b_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             long_q, long_d;
    byte_kind_e       kind;
    logic [7:0]       payload;

    assign kind    = classify(in_byte);
    assign payload = (state_q == ST_ESC) ? (in_byte ^ ESC_XOR) : in_byte;

    always_comb begin
        state_d  = state_q;
        pend_v_d = pend_v_q;
        pend_b_d = pend_b_q;
        cnt_d    = cnt_q;
        long_d   = long_q;
        emit     = 1'b0;
        beat     = '0;
        if (!active) begin
            state_d  = ST_IDLE;
            pend_v_d = 1'b0;
            cnt_d    = '0;
            long_d   = 1'b0;
            if (take) begin
                emit      = 1'b1;
                beat.data = in_byte;
            end
        end else if (take) begin
            if (state_q == ST_IDLE) begin
                if (kind == K_BOF) begin
                    state_d = ST_OPEN;
                    cnt_d   = '0;
                    long_d  = 1'b0;
                end
            end else if (kind == K_BOF) begin
                if (pend_v_q) begin
                    emit              = 1'b1;
                    beat.data         = pend_b_q;
                    beat.eop          = 1'b1;
                    beat.err.sir_bad  = 1'b1;
                    beat.err.too_long = long_q;
                end
                pend_v_d = 1'b0;
                state_d  = ST_OPEN;
                cnt_d    = '0;
                long_d   = 1'b0;
            end else if (kind == K_EOF) begin
                if (pend_v_q) begin
                    emit              = 1'b1;
                    beat.data         = pend_b_q;
                    beat.eop          = 1'b1;
                    beat.err.too_long = long_q;
                end
                pend_v_d = 1'b0;
                state_d  = ST_IDLE;
            end else if (kind == K_ESC && state_q != ST_ESC) begin
                state_d = ST_ESC;
            end else begin
                if (pend_v_q) begin
                    emit      = 1'b1;
                    beat.data = pend_b_q;
                end
                pend_v_d = 1'b1;
                pend_b_d = payload;
                state_d  = ST_DATA;
                if (cnt_q >= max_len) long_d = 1'b1;
                if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pend_v_q <= 1'b0;
            pend_b_q <= '0;
            cnt_q    <= '0;
            long_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            pend_v_q <= pend_v_d;
            pend_b_q <= pend_b_d;
            cnt_q    <= cnt_d;
            long_q   <= long_d;
        end
    end

    assign byte_count = cnt_q;

endmodule

// File: rtl/sir_unwrap_ostage.sv
module sir_unwrap_ostage
    import sir_unwrap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  rx_beat_t beat_in,
    input  logic     out_ready,
    output logic     out_valid,
    output rx_beat_t beat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            beat_q    <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            beat_q    <= beat_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sir_rx_unwrap.sv
module sir_rx_unwrap
    import sir_unwrap_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sir_mode,
    input  logic             filt_en,
    input  logic             test_en,
    input  logic [LEN_W-1:0] max_len,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             out_eop,
    output logic             out_sir_bad,
    output logic             out_too_long,
    output logic [LEN_W-1:0] byte_count,
    output logic [15:0]      flag_word
);

    logic     active;
    logic     take;
    logic     emit;
    rx_beat_t beat_new;
    rx_beat_t beat_out;

    assign active    = filt_en && (sir_mode || test_en);
    assign in_ready  = !out_valid || out_ready;
    assign take      = in_valid && in_ready;
    assign flag_word = {FLAG_EOF, FLAG_BOF};

    sir_unwrap_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .take       (take),
        .in_byte    (in_byte),
        .max_len    (max_len),
        .emit       (emit),
        .beat       (beat_new),
        .byte_count (byte_count)
    );

    sir_unwrap_ostage u_ostage (
        .clk       (clk),
        .rst       (rst),
        .load      (emit),
        .beat_in   (beat_new),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .beat_q    (beat_out)
    );

    assign out_byte     = beat_out.data;
    assign out_eop      = beat_out.eop;
    assign out_sir_bad  = beat_out.err.sir_bad;
    assign out_too_long = beat_out.err.too_long;

endmodule

// File: rtl/sir_rx_unwrap_chk.sv
module sir_rx_unwrap_chk #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             sir_mode,
    input logic             filt_en,
    input logic             test_en,
    input logic             in_valid,
    input logic [7:0]       in_byte,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_byte,
    input logic             out_eop,
    input logic             out_sir_bad,
    input logic             out_too_long,
    input logic [LEN_W-1:0] byte_count
);

    logic act_c;
    assign act_c = filt_en && (sir_mode || test_en);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_eop));

    p_err_eop_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_sir_bad || out_too_long) |-> out_eop);

    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        !act_c && in_valid && in_ready |=> out_valid && out_byte == $past(in_byte) && !out_eop);

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
        byte_count != $past(byte_count) |-> byte_count == '0 || byte_count == $past(byte_count) + 1'b1);

    p_bof_clear_r7: assert property (@(posedge clk) disable iff (rst)
        act_c && in_valid && in_ready && in_byte == 8'hC0 |=> byte_count == '0);

endmodule

bind sir_rx_unwrap sir_rx_unwrap_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sir_rx_unwrap_tb.sv
module sir_rx_unwrap_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 25;

    // {in_byte, exp_valid, exp_byte, exp_eop, exp_bad, exp_long}, max_len = 3
    localparam logic [19:0] TBL [NVEC] = '{
        {8'h55, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'hC0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'hC0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h7D, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h5D, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0},
        {8'h22, 1'b1, 8'h7D, 1'b0, 1'b0, 1'b0},
        {8'hC1, 1'b1, 8'h22, 1'b1, 1'b0, 1'b0},
        {8'h33, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'hC0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h44, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'hC0, 1'b1, 8'h44, 1'b1, 1'b1, 1'b0},
        {8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h02, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0},
        {8'h03, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0},
        {8'h04, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0},
        {8'hC1, 1'b1, 8'h04, 1'b1, 1'b0, 1'b1},
        {8'hC0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'hC1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'hC0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h7D, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'hE0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'h7D, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'hE1, 1'b1, 8'hC0, 1'b0, 1'b0, 1'b0},
        {8'hC1, 1'b1, 8'hC1, 1'b1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        sir_mode, filt_en, test_en;
    logic [11:0] max_len;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        in_ready;
    logic        out_valid, out_ready;
    logic [7:0]  out_byte;
    logic        out_eop, out_sir_bad, out_too_long;
    logic [11:0] byte_count;
    logic [15:0] flag_word;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sir_rx_unwrap dut_i (
        .clk          (clk),
        .rst          (rst),
        .sir_mode     (sir_mode),
        .filt_en      (filt_en),
        .test_en      (test_en),
        .max_len      (max_len),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_byte     (out_byte),
        .out_eop      (out_eop),
        .out_sir_bad  (out_sir_bad),
        .out_too_long (out_too_long),
        .byte_count   (byte_count),
        .flag_word    (flag_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // drive one byte at the falling edge, sample at the next falling edge
    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_beat(input string tag, input logic [7:0] b,
                              input logic eop, input logic bad, input logic lng);
        check({tag, " valid"}, 32'(out_valid), 32'd1);
        check({tag, " byte"},  32'(out_byte),  32'(b));
        check({tag, " flags"}, {29'd0, out_eop, out_sir_bad, out_too_long}, {29'd0, eop, bad, lng});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_byte = '0; out_ready = 1'b1;
        sir_mode = 1'b1; filt_en = 1'b1; test_en = 1'b0; max_len = 12'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R10 reset out_valid", 32'(out_valid), 32'd0);
        check("R10 reset in_ready", 32'(in_ready), 32'd1);
        check("R7 reset byte_count", 32'(byte_count), 32'd0);
        check("R1 flag_word", 32'(flag_word), 32'hC1C0);

        // table walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NVEC; i++) begin
            logic [19:0] v;
            v = TBL[i];
            send(v[19:12]);
            check($sformatf("R2 R4 R5 table %0d valid", i), 32'(out_valid), 32'(v[11]));
            if (v[11]) begin
                check($sformatf("R4 table %0d byte", i), 32'(out_byte), 32'(v[10:3]));
                check($sformatf("R5 R6 R8 table %0d flags", i),
                      {29'd0, out_eop, out_sir_bad, out_too_long}, {29'd0, v[2:0]});
            end
        end

        // R7: counting and reset at new frame start; R6 on the same start flag
        max_len = 12'd100;
        send(8'hC0); send(8'h01); send(8'h02);
        check("R7 count mid frame", 32'(byte_count), 32'd2);
        send(8'hC0);
        check_beat("R6 close by start flag", 8'h02, 1'b1, 1'b1, 1'b0);
        check("R7 count cleared at frame start", 32'(byte_count), 32'd0);
        send(8'hC1);
        check("R5 empty frame emits nothing", 32'(out_valid), 32'd0);

        // R10: stall, then drain and accept in the same cycle
        out_ready = 1'b0;
        send(8'hC0); send(8'hAA); send(8'hBB);
        check_beat("R10 stalled byte", 8'hAA, 1'b0, 1'b0, 1'b0);
        check("R10 in_ready low while stalled", 32'(in_ready), 32'd0);
        send(8'hC1);
        check_beat("R10 held during stall", 8'hAA, 1'b0, 1'b0, 1'b0);
        check("R10 refused byte not counted", 32'(byte_count), 32'd2);
        out_ready = 1'b1;
        send(8'hC1);
        check_beat("R10 drain and accept", 8'hBB, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 output drained", 32'(out_valid), 32'd0);

        // R8: zero limit flags first byte
        max_len = 12'd0;
        send(8'hC0); send(8'h12); send(8'hC1);
        check_beat("R8 limit zero", 8'h12, 1'b1, 1'b0, 1'b1);
        max_len = 12'd100;

        // R9: bypass when filter off
        filt_en = 1'b0;
        send(8'hC0);
        check_beat("R9 bypass start flag", 8'hC0, 1'b0, 1'b0, 1'b0);
        send(8'h7D);
        check_beat("R9 bypass escape", 8'h7D, 1'b0, 1'b0, 1'b0);
        check("R9 bypass count", 32'(byte_count), 32'd0);
        filt_en = 1'b1; sir_mode = 1'b0; test_en = 1'b0;
        send(8'hC1);
        check_beat("R9 not slow mode bypass", 8'hC1, 1'b0, 1'b0, 1'b0);
        test_en = 1'b1;
        send(8'hC0); send(8'h55);
        check("R9 test bit filters", 32'(out_valid), 32'd0);
        send(8'hC1);
        check_beat("R9 test bit frame", 8'h55, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule